// File: doc/BRIEF.md
# ALU With Condition Codes

This block is the integer execute stage for two-operand register instructions. A two-bit function code selects one of four operations: add, subtract, bitwise and, or bitwise exclusive-or. The operation combines a source operand A with a destination operand B, and the destination operand is the left-hand side of a subtraction. The result is combinational and is ready in the same cycle as the operands, so the surrounding datapath can write it back to the destination register.

Three registered condition flags record the last result whose instruction asked for a flag update: zero, negative and signed overflow. The flags change only on a clock edge where the flag-enable input is high. When the enable is low they keep their value. Branch logic downstream reads the flags.

Top module: `alu_cc`

## Requirements
- R1: With `fn` = 0, `res` equals `op_b + op_a` modulo 2^32.
- R2: With `fn` = 1, `res` equals `op_b - op_a` modulo 2^32. The source is subtracted from the destination.
- R3: With `fn` = 2, `res` equals the bitwise AND of the two operands.
- R4: With `fn` = 3, `res` equals the bitwise exclusive-or of the two operands.
- R5: `res` is combinational. It reflects the operands and `fn` in the same cycle, with no clock edge in between.
- R6: On a rising edge with `cc_en` high, `flag_zero` is loaded with 1 exactly when `res` is all zeros.
- R7: On a rising edge with `cc_en` high, `flag_neg` is loaded with bit 31 of `res`.
- R8: For add, an enabled update sets `flag_ovf` exactly when both operands have the same sign bit and `res` has the other sign.
- R9: For subtract, an enabled update sets `flag_ovf` exactly when the operand sign bits differ and the sign of `res` differs from the sign of `op_b`.
- R10: For and and exclusive-or, an enabled update clears `flag_ovf`.
- R11: On a rising edge with `cc_en` low, all three flags keep their previous values, whatever the operands and `fn` are.
- R12: `rst` is synchronous and active high. On a rising edge with `rst` high, the flags become `flag_zero`=1, `flag_neg`=0 and `flag_ovf`=0, even if `cc_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_a | input | 32 | Source operand |
| op_b | input | 32 | Destination operand |
| fn | input | 2 | Operation select: 0 add, 1 subtract, 2 and, 3 xor |
| cc_en | input | 1 | Load the flags from this cycle's result |
| res | output | 32 | Combinational result |
| flag_zero | output | 1 | Registered zero flag |
| flag_neg | output | 1 | Registered sign flag |
| flag_ovf | output | 1 | Registered signed-overflow flag |

## Verification
The assertions assume that `fn`, `cc_en` and the operands are known values at every clock edge outside reset, and that the inputs stay steady between the drive point and the next rising edge. The enable check and the flag checks use `$past` of the result, so they also assume the operands do not change in the half cycle before the edge. The bench keeps to these assumptions. It changes inputs only at the falling edge, holds reset high from time zero, and draws every value from defined constants or `$urandom`, so no input is ever X or Z.

// File: rtl/alu_cc.sv
module alu_cc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   fn,
  input  logic         cc_en,
  output logic [W-1:0] res,
  output logic         flag_zero,
  output logic         flag_neg,
  output logic         flag_ovf
);

  localparam int MSB = W - 1;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_XOR = 2'd3;

  logic [W-1:0] sum, diff;
  logic         ovf_add, ovf_sub, ovf_nxt;

  assign sum  = op_b + op_a;
  assign diff = op_b - op_a;

  always_comb begin
    unique case (fn)
      FN_ADD:  res = sum;
      FN_SUB:  res = diff;
      FN_AND:  res = op_b & op_a;
      default: res = op_b ^ op_a;
    endcase
  end

  assign ovf_add = (op_a[MSB] == op_b[MSB]) && (sum[MSB]  != op_b[MSB]);
  assign ovf_sub = (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_b[MSB]);

  always_comb begin
    unique case (fn)
      FN_ADD:  ovf_nxt = ovf_add;
      FN_SUB:  ovf_nxt = ovf_sub;
      default: ovf_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_zero <= 1'b1;
      flag_neg  <= 1'b0;
      flag_ovf  <= 1'b0;
    end else if (cc_en) begin
      flag_zero <= (res == '0);
      flag_neg  <= res[MSB];
      flag_ovf  <= ovf_nxt;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !cc_en |=> $stable({flag_zero, flag_neg, flag_ovf}));

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    cc_en |=> (flag_zero == ($past(res) == '0)));

  p_sign_r7: assert property (@(posedge clk) disable iff (rst)
    cc_en |=> (flag_neg == $past(res[MSB])));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (cc_en && fn[1]) |=> !flag_ovf);

  p_reset_flags_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flag_zero && !flag_neg && !flag_ovf));

  p_zero_not_neg_r7: assert property (@(posedge clk) disable iff (rst)
    flag_zero |-> !flag_neg);

endmodule

// File: tb/alu_cc_tb_top.sv
module alu_cc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  fn = '0;
  logic        cc_en = 1'b0;
  logic [31:0] res;
  logic        flag_zero, flag_neg, flag_ovf;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic m_z = 1'b1, m_s = 1'b0, m_o = 1'b0;

  always #2 clk = ~clk;

  alu_cc dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .fn(fn), .cc_en(cc_en),
    .res(res), .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf)
  );

  function automatic logic [31:0] exp_res(logic [31:0] a, logic [31:0] b, logic [1:0] f);
    case (f)
      2'd0: return b + a;
      2'd1: return b - a;
      2'd2: return b & a;
      default: return b ^ a;
    endcase
  endfunction

  function automatic logic exp_ovf(logic [31:0] a, logic [31:0] b, logic [1:0] f);
    logic [31:0] r;
    r = exp_res(a, b, f);
    if (f == 2'd0) return (a[31] == b[31]) && (r[31] != b[31]);
    if (f == 2'd1) return (a[31] != b[31]) && (r[31] != b[31]);
    return 1'b0;
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check_flags(string tag);
    vectors++;
    if ({flag_zero, flag_neg, flag_ovf} !== {m_z, m_s, m_o}) begin
      miscompares++;
      $display("FAIL %s: flags zsv actual %b%b%b expected %b%b%b",
               tag, flag_zero, flag_neg, flag_ovf, m_z, m_s, m_o);
    end
  endtask

  // One operation: drive at falling edge, check res mid-cycle, check flags after the edge.
  task automatic apply(string tag, logic [31:0] a, logic [31:0] b, logic [1:0] f, logic en);
    logic [31:0] r;
    @(negedge clk);
    op_a = a; op_b = b; fn = f; cc_en = en;
    r = exp_res(a, b, f);
    #1 check32({tag, " res"}, res, r);
    if (en) begin
      m_z = (r == 32'd0);
      m_s = r[31];
      m_o = exp_ovf(a, b, f);
    end
    @(posedge clk);
    #1 check_flags({tag, " flags"});
  endtask

  task automatic t_reset_r12();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_z = 1'b1; m_s = 1'b0; m_o = 1'b0;
    check_flags("R12 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add_r1_r8();
    apply("R1 add small", 32'd5, 32'd7, 2'd0, 1'b1);
    apply("R8 add pos ovf", 32'h0000_0001, 32'h7fff_ffff, 2'd0, 1'b1);
    apply("R8 add neg ovf", 32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1);
    apply("R6 add wrap zero", 32'h0000_0001, 32'hffff_ffff, 2'd0, 1'b1);
    apply("R8 add mixed signs", 32'hffff_ffff, 32'h7fff_ffff, 2'd0, 1'b1);
  endtask

  task automatic t_sub_r2_r9();
    apply("R2 sub b minus a", 32'd3, 32'd10, 2'd1, 1'b1);
    apply("R7 sub negative", 32'd10, 32'd3, 2'd1, 1'b1);
    apply("R9 sub ovf min", 32'h0000_0001, 32'h8000_0000, 2'd1, 1'b1);
    apply("R9 sub ovf max", 32'hffff_ffff, 32'h7fff_ffff, 2'd1, 1'b1);
    apply("R6 sub equal", 32'h1234_5678, 32'h1234_5678, 2'd1, 1'b1);
    apply("R9 sub same sign", 32'h8000_0000, 32'hffff_ffff, 2'd1, 1'b1);
  endtask

  task automatic t_logic_r3_r4_r10();
    apply("R8 add ovf before logic", 32'h7fff_ffff, 32'h7fff_ffff, 2'd0, 1'b1);
    apply("R3 and R10", 32'hf0f0_f0f0, 32'hff00_ff00, 2'd2, 1'b1);
    apply("R8 add ovf again", 32'h8000_0000, 32'hffff_ffff, 2'd0, 1'b1);
    apply("R4 xor R10", 32'hffff_ffff, 32'h0f0f_0f0f, 2'd3, 1'b1);
    apply("R3 and zero", 32'h5555_5555, 32'haaaa_aaaa, 2'd2, 1'b1);
    apply("R4 xor self zero", 32'h8000_0000, 32'h8000_0000, 2'd3, 1'b1);
  endtask

  task automatic t_hold_r11();
    apply("R11 set flags", 32'h0000_0001, 32'h7fff_ffff, 2'd0, 1'b1);
    apply("R11 hold add", 32'd0, 32'd0, 2'd0, 1'b0);
    apply("R11 hold sub", 32'h0000_0001, 32'h8000_0000, 2'd1, 1'b0);
    apply("R11 hold xor", 32'h1, 32'h1, 2'd3, 1'b0);
  endtask

  task automatic t_comb_r5();
    @(negedge clk);
    op_a = 32'd9; op_b = 32'd4; fn = 2'd1; cc_en = 1'b0;
    #1 check32("R5 comb sub", res, 32'hffff_fffb);
    fn = 2'd3;
    #1 check32("R5 comb xor same cycle", res, 32'd13);
    @(posedge clk); #1;
  endtask

  task automatic t_reset_mid_r12();
    apply("R12 make flags nonreset", 32'h0000_0001, 32'h7fff_ffff, 2'd0, 1'b1);
    @(negedge clk);
    rst = 1'b1; op_a = 32'd1; op_b = 32'h8000_0000; fn = 2'd0; cc_en = 1'b1;
    @(posedge clk); #1;
    m_z = 1'b1; m_s = 1'b0; m_o = 1'b0;
    check_flags("R12 reset beats enable");
    @(negedge clk);
    rst = 1'b0; cc_en = 1'b0;
  endtask

  task automatic t_random();
    logic [31:0] corner [3] = '{32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff};
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 4 == 1) a = corner[$urandom % 3];
      if (i % 4 == 2) b = corner[$urandom % 3];
      if (i % 8 == 3) begin a = corner[i % 3]; b = corner[(i / 3) % 3]; end
      apply("R1 R2 R3 R4 R8 R9 random", a, b, 2'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    t_reset_r12();
    t_comb_r5();
    t_add_r1_r8();
    t_sub_r2_r9();
    t_logic_r3_r4_r10();
    t_hold_r11();
    t_reset_mid_r12();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule